// File: doc/BRIEF.md
# Link Rate Reconfiguration Sequencer

This block moves one serial link channel out of a 25G Ethernet mode with forward error correction and into a 24G radio-interface mode that also uses forward error correction. It does this by running a fixed recipe. The recipe issues transceiver attribute commands and register writes, toggles the clock select lines and pulses an analog reset. Throughout, it holds the channel's TX and RX soft resets asserted. Once every command and write has completed, it releases the resets. It then waits for two ready conditions in turn: first the link core, then the timing path.

A single `start` pulse launches the recipe. A register-write master port with wait-request carries the mode-register writes. An attribute-command port with a request/done handshake carries the serdes, phase-slip and loopback commands. Each wait on `link_status` is bounded by `poll_limit` cycles. If the limit expires, the sequencer parks with a sticky error and a code naming the wait that failed. When the first wait succeeds, `train_en` tells the traffic side that deskew training may begin.

Top module: `link_rate_reseq`

## Requirements
- R1: A `start` pulse drives `tx_rst_n` and `rx_rst_n` low from the next cycle. They stay low during every register write and attribute command. They return high only after the loopback command has completed, and before any status polling.
- R2: The first transaction of the recipe is an attribute command with code 0x0001 and data 0 (serdes off). It comes before any clock-select change, analog reset or register write.
- R3: In hardware mode (`sim_mode`=0) the clock events happen in this order: `ctrl_clk_alt` rises, then `refclk_sel` rises (source 1), then `ctrl_clk_alt` falls. With `sim_mode`=1, `ctrl_clk_alt` never rises but `refclk_sel` still rises.
- R4: `ana_rst` pulses once after the clock swap and before the first register write.
- R5: Exactly seven register writes follow, in this order:
  - 0x40B ← 0x9FFE01E0 (hardware mode) or 0x027E01E0 (simulation mode)
  - 0x30E ← 0x00000083
  - 0x30D ← 0x00000008
  - 0x350 ← 0x003F1002
  - 0x255 ← 0x00000002
  - 0x04C ← 0x00000003
  - 0x084 ← 0x00000084
- R6: `reg_write`, `reg_addr` and `reg_wdata` stay stable while `reg_waitreq` is high. Each write is accepted once, on the first cycle in which `reg_waitreq` is low.
- R7: After the writes come three attribute commands, in this order: code 0x000E data 0 (phase slip), code 0x0001 data 1 (serdes on), and code 0x0008 data 1 (serial loopback). Each command holds `attr_req` until `attr_done` is seen.
- R8: After release, `train_en` stays low until `link_status[3:0]` all read 1. It then rises.
- R9: After `train_en` rises, `done` rises only once `link_status[4]` reads 1. `done` then holds until the next `start`.
- R10: If a wait stays unsatisfied beyond `poll_limit` cycles, `error` sets and `err_code` records which wait failed: 1 for the core wait, 2 for the timing wait. `done` stays low. `error` and `err_code` hold until the next `start`, which clears them to 0.
- R11: A `start` pulse while the recipe is running has no effect. The resets stay asserted and the write and command sequence continues unchanged.
- R12: After `rst`, both soft resets are high, and `reg_write`, `attr_req`, `ctrl_clk_alt`, `refclk_sel`, `train_en`, `done` and `error` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse |
| sim_mode | input | 1 | 1 = skip controller clock moves, use the simulation value at 0x40B |
| poll_limit | input | TMO_W | Cycle budget for each status wait |
| reg_addr | output | 12 | Register write address |
| reg_wdata | output | 32 | Register write data |
| reg_write | output | 1 | Write strobe |
| reg_waitreq | input | 1 | Target stall; write is held while high |
| attr_code | output | 16 | Attribute command code |
| attr_data | output | 16 | Attribute command argument |
| attr_req | output | 1 | Command request, held until done |
| attr_done | input | 1 | Command completion pulse |
| tx_rst_n | output | 1 | TX soft reset, active low |
| rx_rst_n | output | 1 | RX soft reset, active low |
| ctrl_clk_alt | output | 1 | Controller clock on the alternate reference |
| refclk_sel | output | 1 | Channel reference select, 1 = source 1 |
| ana_rst | output | 1 | One-cycle analog reset pulse |
| link_status | input | 5 | [3:0] core ready bits, [4] timing ready |
| train_en | output | 1 | Deskew training traffic may start |
| done | output | 1 | Sequence finished |
| error | output | 1 | Sticky timeout flag |
| err_code | output | 2 | 0 none, 1 core wait, 2 timing wait |

## Verification
The bench builds the block with TMO_W=8, so `poll_limit` is an 8-bit budget. A limit of 20 makes both timeout exits fire within a few tens of cycles of release. The stimulus covers both modes. In hardware mode, a full run is compared event by event against an expected table. The bench's write target stalls for 0 to 3 cycles, which exercises the held-write handshake. In the timeout runs, status is either left low or raised only partly, so that each error code and the clearing of the sticky flag can be observed.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int CODE_W     = 16;
    localparam int STAT_W     = 5;
    localparam int CORE_BITS  = 4;
    localparam int TIMING_BIT = 4;
    localparam int NSTEP      = 19;
    localparam int STEP_W     = $clog2(NSTEP + 1);

    localparam logic [CODE_W-1:0] AC_SERDES   = 16'h0001;
    localparam logic [CODE_W-1:0] AC_SLIP     = 16'h000E;
    localparam logic [CODE_W-1:0] AC_LOOPBACK = 16'h0008;

    localparam logic [1:0] ERR_NONE   = 2'd0;
    localparam logic [1:0] ERR_CORE   = 2'd1;
    localparam logic [1:0] ERR_TIMING = 2'd2;

    typedef enum logic [3:0] {
        K_ATTR, K_CLK_ALT_ON, K_REFSEL, K_CLK_ALT_OFF, K_ANA,
        K_WRITE, K_RELEASE, K_POLL_CORE, K_POLL_TIMING, K_END
    } kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_ISSUE, S_WAIT_WR, S_WAIT_ATTR, S_POLL, S_FIN
    } state_e;

    typedef struct packed {
        kind_e               kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [CODE_W-1:0]   code;
    } step_t;

    function automatic step_t mk(input kind_e k, input logic [ADDR_W-1:0] a,
                                 input logic [DATA_W-1:0] d, input logic [CODE_W-1:0] c);
        step_t s;
        s.kind = k;
        s.addr = a;
        s.data = d;
        s.code = c;
        return s;
    endfunction

    // Recipe decoded from the step index; mode only alters the 0x40B value
    function automatic step_t recipe(input logic [STEP_W-1:0] idx, input logic sim);
        case (idx)
            5'd0:    return mk(K_ATTR, '0, 32'd0, AC_SERDES);
            5'd1:    return mk(K_CLK_ALT_ON, '0, '0, '0);
            5'd2:    return mk(K_REFSEL, '0, '0, '0);
            5'd3:    return mk(K_CLK_ALT_OFF, '0, '0, '0);
            5'd4:    return mk(K_ANA, '0, '0, '0);
            5'd5:    return mk(K_WRITE, 12'h40B, sim ? 32'h027E01E0 : 32'h9FFE01E0, '0);
            5'd6:    return mk(K_WRITE, 12'h30E, 32'h00000083, '0);
            5'd7:    return mk(K_WRITE, 12'h30D, 32'h00000008, '0);
            5'd8:    return mk(K_WRITE, 12'h350, 32'h003F1002, '0);
            5'd9:    return mk(K_WRITE, 12'h255, 32'h00000002, '0);
            5'd10:   return mk(K_WRITE, 12'h04C, 32'h00000003, '0);
            5'd11:   return mk(K_WRITE, 12'h084, 32'h00000084, '0);
            5'd12:   return mk(K_ATTR, '0, 32'd0, AC_SLIP);
            5'd13:   return mk(K_ATTR, '0, 32'd1, AC_SERDES);
            5'd14:   return mk(K_ATTR, '0, 32'd1, AC_LOOPBACK);
            5'd15:   return mk(K_RELEASE, '0, '0, '0);
            5'd16:   return mk(K_POLL_CORE, '0, '0, '0);
            5'd17:   return mk(K_POLL_TIMING, '0, '0, '0);
            default: return mk(K_END, '0, '0, '0);
        endcase
    endfunction

endpackage

// File: rtl/lrr_wr_master.sv
module lrr_wr_master import lrr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              waitreq,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              write,
    output logic              fin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            write <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else if (go) begin
            write <= 1'b1;
            addr  <= addr_in;
            wdata <= data_in;
        end else if (write && !waitreq) begin
            write <= 1'b0;
        end
    end

    assign fin = write & ~waitreq;

    assert_write_held_R6: assert property (@(posedge clk) disable iff (rst)
        (write && waitreq) |=> (write && $stable(addr) && $stable(wdata)));
endmodule

// File: rtl/lrr_attr_master.sv
module lrr_attr_master import lrr_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [CODE_W-1:0] code_in,
    input  logic [CODE_W-1:0] data_in,
    input  logic              cmd_done,
    output logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] data,
    output logic              req,
    output logic              fin
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= 1'b0;
            code <= '0;
            data <= '0;
        end else if (go) begin
            req  <= 1'b1;
            code <= code_in;
            data <= data_in;
        end else if (req && cmd_done) begin
            req <= 1'b0;
        end
    end

    assign fin = req & cmd_done;

    assert_cmd_held_R7: assert property (@(posedge clk) disable iff (rst)
        (req && !cmd_done) |=> (req && $stable(code) && $stable(data)));
endmodule

// File: rtl/lrr_poll_timer.sv
module lrr_poll_timer #(
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             cond,
    input  logic [TMO_W-1:0] limit,
    output logic             hit,
    output logic             expire
);
    logic             active;
    logic [TMO_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (go) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (hit || expire) active <= 1'b0;
            else               cnt    <= cnt + 1'b1;
        end
    end

    assign hit    = active & cond;
    assign expire = active & ~cond & (cnt >= limit);
endmodule

// File: rtl/link_rate_reseq.sv
module link_rate_reseq import lrr_pkg::*; #(
    parameter int TMO_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sim_mode,
    input  logic [TMO_W-1:0]  poll_limit,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_write,
    input  logic              reg_waitreq,
    output logic [CODE_W-1:0] attr_code,
    output logic [CODE_W-1:0] attr_data,
    output logic              attr_req,
    input  logic              attr_done,
    output logic              tx_rst_n,
    output logic              rx_rst_n,
    output logic              ctrl_clk_alt,
    output logic              refclk_sel,
    output logic              ana_rst,
    input  logic [STAT_W-1:0] link_status,
    output logic              train_en,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_code
);
    state_e             state;
    logic [STEP_W-1:0]  step;
    step_t              cur;
    logic               rst_hold;
    logic               wr_go, wr_fin, at_go, at_fin;
    logic               poll_go, poll_cond, poll_hit, poll_expire;

    assign cur       = recipe(step, sim_mode);
    assign wr_go     = (state == S_ISSUE) && (cur.kind == K_WRITE);
    assign at_go     = (state == S_ISSUE) && (cur.kind == K_ATTR);
    assign poll_go   = (state == S_ISSUE) &&
                       ((cur.kind == K_POLL_CORE) || (cur.kind == K_POLL_TIMING));
    assign poll_cond = (cur.kind == K_POLL_CORE) ? (&link_status[CORE_BITS-1:0])
                                                 : link_status[TIMING_BIT];
    assign tx_rst_n  = ~rst_hold;
    assign rx_rst_n  = ~rst_hold;

    lrr_wr_master u_wr (
        .clk(clk), .rst(rst), .go(wr_go), .addr_in(cur.addr), .data_in(cur.data),
        .waitreq(reg_waitreq), .addr(reg_addr), .wdata(reg_wdata),
        .write(reg_write), .fin(wr_fin)
    );

    lrr_attr_master u_attr (
        .clk(clk), .rst(rst), .go(at_go), .code_in(cur.code),
        .data_in(cur.data[CODE_W-1:0]), .cmd_done(attr_done),
        .code(attr_code), .data(attr_data), .req(attr_req), .fin(at_fin)
    );

    lrr_poll_timer #(.TMO_W(TMO_W)) u_poll (
        .clk(clk), .rst(rst), .go(poll_go), .cond(poll_cond), .limit(poll_limit),
        .hit(poll_hit), .expire(poll_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_IDLE;
            step         <= '0;
            rst_hold     <= 1'b0;
            ctrl_clk_alt <= 1'b0;
            refclk_sel   <= 1'b0;
            ana_rst      <= 1'b0;
            train_en     <= 1'b0;
            done         <= 1'b0;
            error        <= 1'b0;
            err_code     <= ERR_NONE;
        end else begin
            ana_rst <= 1'b0;
            case (state)
                S_IDLE, S_FIN: begin
                    if (start) begin
                        step     <= '0;
                        state    <= S_ISSUE;
                        rst_hold <= 1'b1;
                        train_en <= 1'b0;
                        done     <= 1'b0;
                        error    <= 1'b0;
                        err_code <= ERR_NONE;
                    end
                end
                S_ISSUE: begin
                    case (cur.kind)
                        K_WRITE:       state <= S_WAIT_WR;
                        K_ATTR:        state <= S_WAIT_ATTR;
                        K_POLL_CORE:   state <= S_POLL;
                        K_POLL_TIMING: begin
                            train_en <= 1'b1;
                            state    <= S_POLL;
                        end
                        K_CLK_ALT_ON: begin
                            if (!sim_mode) ctrl_clk_alt <= 1'b1;
                            step <= step + 1'b1;
                        end
                        K_REFSEL: begin
                            refclk_sel <= 1'b1;
                            step       <= step + 1'b1;
                        end
                        K_CLK_ALT_OFF: begin
                            ctrl_clk_alt <= 1'b0;
                            step         <= step + 1'b1;
                        end
                        K_ANA: begin
                            ana_rst <= 1'b1;
                            step    <= step + 1'b1;
                        end
                        K_RELEASE: begin
                            rst_hold <= 1'b0;
                            step     <= step + 1'b1;
                        end
                        default: begin
                            done  <= 1'b1;
                            state <= S_FIN;
                        end
                    endcase
                end
                S_WAIT_WR: begin
                    if (wr_fin) begin
                        step  <= step + 1'b1;
                        state <= S_ISSUE;
                    end
                end
                S_WAIT_ATTR: begin
                    if (at_fin) begin
                        step  <= step + 1'b1;
                        state <= S_ISSUE;
                    end
                end
                S_POLL: begin
                    if (poll_hit) begin
                        step  <= step + 1'b1;
                        state <= S_ISSUE;
                    end else if (poll_expire) begin
                        error    <= 1'b1;
                        err_code <= (cur.kind == K_POLL_CORE) ? ERR_CORE : ERR_TIMING;
                        state    <= S_FIN;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_resets_held_R1: assert property (@(posedge clk) disable iff (rst)
        (reg_write || attr_req) |-> (!tx_rst_n && !rx_rst_n));

    assert_refsel_order_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(refclk_sel) |-> (ctrl_clk_alt || sim_mode));

    assert_train_released_R8: assert property (@(posedge clk) disable iff (rst)
        train_en |-> (tx_rst_n && rx_rst_n));

    assert_done_after_train_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> train_en);

    assert_outcome_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    assert_error_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> (error && $stable(err_code)));
endmodule

// File: tb/sim_link_rate_reseq.sv
module sim_link_rate_reseq;
    import lrr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sim_mode = 1'b0;
    logic [7:0] poll_limit = 8'd200;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] reg_wdata;
    logic reg_write;
    logic reg_waitreq = 1'b1;
    logic [CODE_W-1:0] attr_code, attr_data;
    logic attr_req;
    logic attr_done = 1'b0;
    logic tx_rst_n, rx_rst_n, ctrl_clk_alt, refclk_sel, ana_rst;
    logic [STAT_W-1:0] link_status = '0;
    logic train_en, done, error;
    logic [1:0] err_code;

    always #2 clk = ~clk;

    link_rate_reseq #(.TMO_W(8)) u0 (
        .clk(clk), .rst(rst), .start(start), .sim_mode(sim_mode), .poll_limit(poll_limit),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_write(reg_write),
        .reg_waitreq(reg_waitreq), .attr_code(attr_code), .attr_data(attr_data),
        .attr_req(attr_req), .attr_done(attr_done), .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n),
        .ctrl_clk_alt(ctrl_clk_alt), .refclk_sel(refclk_sel), .ana_rst(ana_rst),
        .link_status(link_status), .train_en(train_en), .done(done), .error(error),
        .err_code(err_code)
    );

    // Expected hardware-mode event trace: {kind, addr or code, data}
    // kinds: 1 cmd, 2 alt rise, 3 refsel rise, 4 alt fall, 5 analog, 6 write,
    //        7 release, 8 train, 9 done
    localparam logic [47:0] VEC [18] = '{
        {4'd1, 12'h001, 32'h0}, {4'd2, 12'h0, 32'h0}, {4'd3, 12'h0, 32'h0},
        {4'd4, 12'h0, 32'h0},   {4'd5, 12'h0, 32'h0},
        {4'd6, 12'h40B, 32'h9FFE01E0}, {4'd6, 12'h30E, 32'h00000083},
        {4'd6, 12'h30D, 32'h00000008}, {4'd6, 12'h350, 32'h003F1002},
        {4'd6, 12'h255, 32'h00000002}, {4'd6, 12'h04C, 32'h00000003},
        {4'd6, 12'h084, 32'h00000084},
        {4'd1, 12'h00E, 32'h0}, {4'd1, 12'h001, 32'h1}, {4'd1, 12'h008, 32'h1},
        {4'd7, 12'h0, 32'h0},   {4'd8, 12'h0, 32'h0},   {4'd9, 12'h0, 32'h0}
    };

    int checks = 0;
    int errors = 0;
    logic [47:0] log_m [64];
    int log_n = 0;
    bit logging = 1'b0;
    bit stall_bad = 1'b0;
    int ca_rises = 0;

    function automatic string tag_of(input int i);
        if (i == 0) return "R2";
        if (i <= 3) return "R3";
        if (i == 4) return "R4";
        if (i <= 11) return "R5";
        if (i <= 14) return "R7";
        if (i == 15) return "R1";
        if (i == 16) return "R8";
        return "R9";
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] k, input logic [11:0] a, input logic [31:0] d);
        if (logging && log_n < 64) begin
            log_m[log_n] = {k, a, d};
            log_n++;
        end
    endtask

    // Responders and event monitor, all at the falling edge
    initial begin
        int wcnt = 0, wlat = 0, wr_total = 0, acnt = 0;
        bit wr_busy = 1'b0;
        logic [ADDR_W-1:0] wa_prev = '0;
        logic [DATA_W-1:0] wd_prev = '0;
        logic p_ca = 1'b0, p_rs = 1'b0, p_tx = 1'b1, p_tr = 1'b0, p_dn = 1'b0;
        forever begin
            @(negedge clk);
            if (reg_write) begin
                if (wr_busy && (reg_addr != wa_prev || reg_wdata != wd_prev)) stall_bad = 1'b1;
                wr_busy = 1'b1;
                wa_prev = reg_addr;
                wd_prev = reg_wdata;
                if (wcnt >= wlat) begin
                    reg_waitreq = 1'b0;
                    push(4'd6, reg_addr, reg_wdata);
                    wcnt = 0;
                    wr_total++;
                    wlat = wr_total % 4;
                end else begin
                    reg_waitreq = 1'b1;
                    wcnt++;
                end
            end else begin
                reg_waitreq = 1'b1;
                wr_busy = 1'b0;
            end
            if (attr_done) begin
                attr_done = 1'b0;
            end else if (attr_req) begin
                if (acnt >= 2) begin
                    attr_done = 1'b1;
                    push(4'd1, attr_code[11:0], {16'h0, attr_data});
                    acnt = 0;
                end else acnt++;
            end
            if (ctrl_clk_alt && !p_ca) begin push(4'd2, 12'h0, 32'h0); if (logging) ca_rises++; end
            if (!ctrl_clk_alt && p_ca) push(4'd4, 12'h0, 32'h0);
            if (refclk_sel && !p_rs) push(4'd3, 12'h0, 32'h0);
            if (ana_rst) push(4'd5, 12'h0, 32'h0);
            if (tx_rst_n && !p_tx) push(4'd7, 12'h0, 32'h0);
            if (train_en && !p_tr) push(4'd8, 12'h0, 32'h0);
            if (done && !p_dn) push(4'd9, 12'h0, 32'h0);
            p_ca = ctrl_clk_alt; p_rs = refclk_sel; p_tx = tx_rst_n;
            p_tr = train_en; p_dn = done;
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R12 reset state
        chk(tx_rst_n && rx_rst_n, "R12", "soft resets idle", {tx_rst_n, rx_rst_n}, 2'b11);
        chk(!reg_write && !attr_req, "R12", "ports idle", {reg_write, attr_req}, 0);
        chk(!ctrl_clk_alt && !refclk_sel, "R12", "clock selects", {ctrl_clk_alt, refclk_sel}, 0);
        chk(!train_en && !done && !error, "R12", "flags", {train_en, done, error}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // Run 1: hardware mode, full trace
        logging = 1'b1;
        log_n = 0;
        pulse_start();
        chk(!tx_rst_n && !rx_rst_n, "R1", "resets asserted after start", {tx_rst_n, rx_rst_n}, 0);
        for (int i = 0; i < 3000 && log_n < 8; i++) @(negedge clk);
        pulse_start();
        chk(!tx_rst_n && !error && !done, "R11", "start while running", {tx_rst_n, error, done}, 0);
        for (int i = 0; i < 3000 && !tx_rst_n; i++) @(negedge clk);
        chk(rx_rst_n, "R1", "rx released with tx", rx_rst_n, 1);
        link_status = 5'h07;
        repeat (30) @(negedge clk);
        chk(!train_en, "R8", "train held with partial core status", train_en, 0);
        link_status = 5'h0F;
        for (int i = 0; i < 10 && !train_en; i++) @(negedge clk);
        chk(train_en, "R8", "train after core ready", train_en, 1);
        repeat (20) @(negedge clk);
        chk(!done, "R9", "done held without timing ready", done, 0);
        link_status = 5'h1F;
        for (int i = 0; i < 10 && !done; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(done && !error, "R9", "done holds", {done, error}, 2'b10);
        chk(log_n == 18, "R5", "event count", log_n, 18);
        for (int i = 0; i < 18; i++)
            chk(log_m[i] == VEC[i], tag_of(i), $sformatf("event %0d", i), log_m[i], VEC[i]);
        chk(!stall_bad, "R6", "write held during stall", stall_bad, 0);

        // Run 2: simulation mode
        logging = 1'b1;
        log_n = 0;
        ca_rises = 0;
        sim_mode = 1'b1;
        link_status = '0;
        pulse_start();
        for (int i = 0; i < 3000 && !tx_rst_n; i++) @(negedge clk);
        link_status = 5'h1F;
        for (int i = 0; i < 50 && !done; i++) @(negedge clk);
        chk(done, "R9", "sim mode completes", done, 1);
        chk(ca_rises == 0, "R3", "no controller clock move in sim mode", ca_rises, 0);
        chk(refclk_sel, "R3", "refclk source 1", refclk_sel, 1);
        begin
            logic [31:0] d40b = '0;
            for (int i = 0; i < log_n; i++)
                if (log_m[i][47:44] == 4'd6 && log_m[i][43:32] == 12'h40B) d40b = log_m[i][31:0];
            chk(d40b == 32'h027E01E0, "R5", "sim value at 0x40B", d40b, 32'h027E01E0);
        end
        logging = 1'b0;
        sim_mode = 1'b0;

        // Run 3: core wait timeout
        link_status = '0;
        poll_limit = 8'd20;
        pulse_start();
        for (int i = 0; i < 3000 && !error; i++) @(negedge clk);
        chk(error && err_code == 2'd1 && !done, "R10", "core timeout code",
            {error, err_code, done}, {1'b1, 2'd1, 1'b0});
        chk(!train_en, "R8", "no training after core timeout", train_en, 0);
        link_status = 5'h1F;
        repeat (10) @(negedge clk);
        chk(error && err_code == 2'd1 && !done, "R10", "error sticky",
            {error, err_code, done}, {1'b1, 2'd1, 1'b0});

        // Run 4: restart clears, then timing wait timeout
        link_status = 5'h0F;
        pulse_start();
        chk(!error && err_code == 2'd0, "R10", "start clears error", {error, err_code}, 0);
        for (int i = 0; i < 3000 && !error; i++) @(negedge clk);
        chk(error && err_code == 2'd2, "R10", "timing timeout code", {error, err_code}, {1'b1, 2'd2});
        chk(train_en && !done, "R9", "no done without timing ready", {train_en, done}, 2'b10);

        summary();
        $finish;
    end
endmodule